// File: doc/BRIEF.md
# Smart Card Cold Activation and Answer-to-Reset Capture Sequencer

This block runs one contact smart card slot through a cold start and collects the bytes the card sends back after reset. A single start pulse, given while the block is idle, starts a session. The block first checks that a card is seated. It then puts the slot into a known dead state, chooses the slowest card clock ratio and the middle supply class, and applies power. It holds the card in reset for a fixed number of card clock cycles and then releases it. After that it listens for the answer from the card.

Received bytes come from an external character receiver as a data byte with a one-cycle strobe. The block repeats each accepted byte on its own output for one cycle and counts the bytes. The session ends in one of three ways:
- the card never answers, which raises the no-response flag;
- the line stays silent for a long waiting period after the last byte, which raises the done flag;
- no card is seated at start, which raises the no-card flag and never applies power.

Every timing window is counted in card clock cycles. The card clock rate comes from an internal divider that follows the selected ratio. At the end of a session, power is removed, reset is driven again and the indicator LED goes dark.

Top module: `scard_atr_seq`

## Requirements
- R1: After reset, power is off, the card reset output is low (asserted), the LED is off, all three flags and the byte count are zero, the divider select reads 2'b00 (divide by 1) and the supply class select reads 2'b10 (1.8 V class).
- R2: A start seen in idle while card-present is low raises the no-card flag on the next cycle. Power and the LED stay off.
- R3: A start accepted with a card present turns the LED on. Before power rises, the divider select is 2'b11 (divide by 8; 2'b01 is /2, 2'b10 is /4) and the supply class select is 2'b01 (3.0 V class; 2'b00 is 5 V).
- R4: The card reset output goes high exactly HOLD_CYC card clock cycles after power is applied. At divide by 8 this is 8*HOLD_CYC+1 system cycles after power rises.
- R5: If no byte arrives within FIRST_WAIT_CYC plus GRACE_ETU*ETU_CYC card cycles after reset release, the no-response flag is raised and the session shuts down. The reset output stays high for 8*(FIRST_WAIT_CYC+GRACE_ETU*ETU_CYC)+2 system cycles.
- R6: A byte strobed in while waiting for the answer or capturing it appears on the capture output one cycle later, with the valid strobe high for that single cycle, and the byte count increments by one.
- R7: After the last byte, capture ends once WAIT_ETU elementary time units pass with no new byte, and the done flag is raised. Each unit is ETU_CYC card cycles plus one system cycle. Power falls WAIT_ETU*(8*ETU_CYC+1)+2 system cycles after the cycle in which the last byte was strobed.
- R8: Received-byte strobes outside the answer-waiting and capture phases produce no capture strobe and leave the byte count unchanged.
- R9: When a session ends, power is off, the card reset output is low and the LED is off.
- R10: Start is ignored unless the block is idle. An accepted start clears all three flags and the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (reference for the card clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Session start request |
| card_present_i | input | 1 | High when a card is seated |
| rx_valid_i | input | 1 | One-cycle strobe for a received character |
| rx_data_i | input | 8 | Received character |
| card_pwr_o | output | 1 | Card supply enable |
| card_rst_n_o | output | 1 | Card reset, low = asserted |
| clk_div_sel_o | output | 2 | Card clock ratio select |
| vcc_sel_o | output | 2 | Supply class select |
| led_o | output | 1 | Slot activity indicator |
| atr_valid_o | output | 1 | Captured-byte strobe |
| atr_data_o | output | 8 | Captured byte |
| atr_count_o | output | CNT_W | Number of bytes captured in this session |
| done_o | output | 1 | Answer captured and session closed |
| no_card_o | output | 1 | Session aborted, no card seated |
| no_resp_o | output | 1 | Card gave no answer |

## Verification
The checker assumes that the receiver strobe is a single-cycle pulse per character and that all inputs are synchronous to the system clock. It relies on this when it ties every capture strobe to a receiver strobe one cycle earlier. The bench drives every input on the falling edge and raises each strobe or start for exactly one cycle. Bytes are spaced well inside the silence window, and the stray strobes and starts are placed in phases where the requirements say they must be ignored.

// File: rtl/scard_pkg.sv
package scard_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEACT,
        ST_POWER_UP,
        ST_RESET_HOLD,
        ST_WAIT_FIRST,
        ST_CAPTURE,
        ST_SHUTDOWN
    } seq_state_e;

    typedef enum logic [1:0] {
        DIV_1 = 2'b00,
        DIV_2 = 2'b01,
        DIV_4 = 2'b10,
        DIV_8 = 2'b11
    } clk_div_e;

    typedef enum logic [1:0] {
        VCLS_5V0 = 2'b00,
        VCLS_3V0 = 2'b01,
        VCLS_1V8 = 2'b10
    } vcc_class_e;

endpackage

// File: rtl/scard_clkdiv.sv
// Card clock enable generator: one tick per 2**sel reference cycles.
module scard_clkdiv #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < CNT_W; i++) begin
            mask[i] = (i < int'(sel));
        end
    end

    assign tick = ((cnt_q & mask) == mask);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (clear || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/scard_win_timer.sv
// Window counter: counts ticks after a clear and reports reaching the limit.
module scard_win_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q, cnt_d;

    assign hit = (cnt_q >= limit);

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick && !hit) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/scard_atr_seq.sv
module scard_atr_seq
    import scard_pkg::*;
#(
    parameter int HOLD_CYC       = 400,
    parameter int FIRST_WAIT_CYC = 40000,
    parameter int GRACE_ETU      = 13,
    parameter int ETU_CYC        = 372,
    parameter int WAIT_ETU       = 9600,
    parameter int CNT_W          = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             card_present_i,
    input  logic             rx_valid_i,
    input  logic [7:0]       rx_data_i,
    output logic             card_pwr_o,
    output logic             card_rst_n_o,
    output logic [1:0]       clk_div_sel_o,
    output logic [1:0]       vcc_sel_o,
    output logic             led_o,
    output logic             atr_valid_o,
    output logic [7:0]       atr_data_o,
    output logic [CNT_W-1:0] atr_count_o,
    output logic             done_o,
    output logic             no_card_o,
    output logic             no_resp_o
);
    localparam int WAIT_LIMIT = FIRST_WAIT_CYC + GRACE_ETU * ETU_CYC;
    localparam int MAX_A      = (WAIT_LIMIT > HOLD_CYC) ? WAIT_LIMIT : HOLD_CYC;
    localparam int MAX_CYC    = (MAX_A > ETU_CYC) ? MAX_A : ETU_CYC;
    localparam int CYC_W      = $clog2(MAX_CYC + 1);
    localparam int ETU_W      = $clog2(WAIT_ETU + 1);

    typedef struct packed {
        seq_state_e       st;
        logic             pwr;
        logic             rst_n;
        clk_div_e         div;
        vcc_class_e       vcc;
        logic             led;
        logic             atr_valid;
        logic [7:0]       atr_data;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             no_card;
        logic             no_resp;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic             card_tick;
    logic             clr_cyc, clr_etu, etu_tick;
    logic             cyc_hit, etu_hit;
    logic [CYC_W-1:0] cyc_limit;

    scard_clkdiv #(.SEL_W(2)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clr_cyc),
        .sel   (r_q.div),
        .tick  (card_tick)
    );

    scard_win_timer #(.W(CYC_W)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clr_cyc),
        .tick  (card_tick),
        .limit (cyc_limit),
        .hit   (cyc_hit)
    );

    scard_win_timer #(.W(ETU_W)) u_etu (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clr_etu),
        .tick  (etu_tick),
        .limit (ETU_W'(WAIT_ETU)),
        .hit   (etu_hit)
    );

    always_comb begin
        case (r_q.st)
            ST_RESET_HOLD: cyc_limit = CYC_W'(HOLD_CYC);
            ST_WAIT_FIRST: cyc_limit = CYC_W'(WAIT_LIMIT);
            default:       cyc_limit = CYC_W'(ETU_CYC);
        endcase
    end

    always_comb begin
        r_d         = r_q;
        r_d.atr_valid = 1'b0;
        clr_cyc     = 1'b0;
        clr_etu     = 1'b0;
        etu_tick    = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.done    = 1'b0;
                    r_d.no_resp = 1'b0;
                    r_d.cnt     = '0;
                    if (card_present_i) begin
                        r_d.no_card = 1'b0;
                        r_d.led     = 1'b1;
                        r_d.st      = ST_DEACT;
                    end else begin
                        r_d.no_card = 1'b1;
                    end
                end
            end
            ST_DEACT: begin
                r_d.pwr   = 1'b0;
                r_d.rst_n = 1'b0;
                r_d.div   = DIV_8;
                r_d.vcc   = VCLS_3V0;
                r_d.st    = ST_POWER_UP;
            end
            ST_POWER_UP: begin
                r_d.pwr = 1'b1;
                clr_cyc = 1'b1;
                r_d.st  = ST_RESET_HOLD;
            end
            ST_RESET_HOLD: begin
                if (cyc_hit) begin
                    r_d.rst_n = 1'b1;
                    clr_cyc   = 1'b1;
                    r_d.st    = ST_WAIT_FIRST;
                end
            end
            ST_WAIT_FIRST, ST_CAPTURE: begin
                if (rx_valid_i) begin
                    r_d.atr_valid = 1'b1;
                    r_d.atr_data  = rx_data_i;
                    if (r_q.cnt != '1) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                    clr_cyc = 1'b1;
                    clr_etu = 1'b1;
                    r_d.st  = ST_CAPTURE;
                end else if (r_q.st == ST_WAIT_FIRST) begin
                    if (cyc_hit) begin
                        r_d.no_resp = 1'b1;
                        r_d.st      = ST_SHUTDOWN;
                    end
                end else if (etu_hit) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_SHUTDOWN;
                end else if (cyc_hit) begin
                    etu_tick = 1'b1;
                    clr_cyc  = 1'b1;
                end
            end
            ST_SHUTDOWN: begin
                r_d.pwr   = 1'b0;
                r_d.rst_n = 1'b0;
                r_d.led   = 1'b0;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st        <= ST_IDLE;
            r_q.pwr       <= 1'b0;
            r_q.rst_n     <= 1'b0;
            r_q.div       <= DIV_1;
            r_q.vcc       <= VCLS_1V8;
            r_q.led       <= 1'b0;
            r_q.atr_valid <= 1'b0;
            r_q.atr_data  <= '0;
            r_q.cnt       <= '0;
            r_q.done      <= 1'b0;
            r_q.no_card   <= 1'b0;
            r_q.no_resp   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign card_pwr_o    = r_q.pwr;
    assign card_rst_n_o  = r_q.rst_n;
    assign clk_div_sel_o = r_q.div;
    assign vcc_sel_o     = r_q.vcc;
    assign led_o         = r_q.led;
    assign atr_valid_o   = r_q.atr_valid;
    assign atr_data_o    = r_q.atr_data;
    assign atr_count_o   = r_q.cnt;
    assign done_o        = r_q.done;
    assign no_card_o     = r_q.no_card;
    assign no_resp_o     = r_q.no_resp;
endmodule

// File: rtl/scard_atr_seq_chk.sv
module scard_atr_seq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid_i,
    input logic             card_pwr_o,
    input logic             card_rst_n_o,
    input logic [1:0]       clk_div_sel_o,
    input logic [1:0]       vcc_sel_o,
    input logic             led_o,
    input logic             atr_valid_o,
    input logic [CNT_W-1:0] atr_count_o,
    input logic             done_o,
    input logic             no_card_o,
    input logic             no_resp_o
);
    AST_NO_CARD_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        no_card_o |-> (!card_pwr_o && !led_o)); // R2

    AST_PWR_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_pwr_o) |-> (clk_div_sel_o == 2'b11 && vcc_sel_o == 2'b01)); // R3

    AST_LED_WHILE_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        card_pwr_o |-> led_o); // R3

    AST_RST_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst_n_o |-> card_pwr_o); // R4

    AST_ATR_FROM_RX: assert property (@(posedge clk) disable iff (!rst_n)
        atr_valid_o |-> ($past(rx_valid_i) && atr_count_o != '0)); // R6

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, no_card_o, no_resp_o})); // R7

    AST_END_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_pwr_o) |-> (!card_rst_n_o && !led_o)); // R9
endmodule

bind scard_atr_seq scard_atr_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid_i    (rx_valid_i),
    .card_pwr_o    (card_pwr_o),
    .card_rst_n_o  (card_rst_n_o),
    .clk_div_sel_o (clk_div_sel_o),
    .vcc_sel_o     (vcc_sel_o),
    .led_o         (led_o),
    .atr_valid_o   (atr_valid_o),
    .atr_count_o   (atr_count_o),
    .done_o        (done_o),
    .no_card_o     (no_card_o),
    .no_resp_o     (no_resp_o)
);

// File: tb/scard_atr_seq_bench.sv
module scard_atr_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 8;
    localparam int FIRST      = 40;
    localparam int GRACE      = 3;
    localparam int ETU        = 4;
    localparam int WETU       = 10;
    localparam int CW         = 8;
    localparam int WATCHDOG   = 100000;

    localparam int NV = 4;
    localparam bit VEC_PRES  [NV] = '{1'b0, 1'b1, 1'b1, 1'b1};
    localparam int VEC_BYTES [NV] = '{0, 0, 1, 3};
    localparam bit VEC_NOCARD[NV] = '{1'b1, 1'b0, 1'b0, 1'b0};
    localparam bit VEC_NORESP[NV] = '{1'b0, 1'b1, 1'b0, 1'b0};
    localparam bit VEC_DONE  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          card_present_i = 1'b0;
    logic          rx_valid_i = 1'b0;
    logic [7:0]    rx_data_i = '0;
    logic          card_pwr_o, card_rst_n_o, led_o;
    logic [1:0]    clk_div_sel_o, vcc_sel_o;
    logic          atr_valid_o;
    logic [7:0]    atr_data_o;
    logic [CW-1:0] atr_count_o;
    logic          done_o, no_card_o, no_resp_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scard_atr_seq #(
        .HOLD_CYC(HOLD), .FIRST_WAIT_CYC(FIRST), .GRACE_ETU(GRACE),
        .ETU_CYC(ETU), .WAIT_ETU(WETU), .CNT_W(CW)
    ) u_scard_atr_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .card_present_i(card_present_i), .rx_valid_i(rx_valid_i),
        .rx_data_i(rx_data_i), .card_pwr_o(card_pwr_o),
        .card_rst_n_o(card_rst_n_o), .clk_div_sel_o(clk_div_sel_o),
        .vcc_sel_o(vcc_sel_o), .led_o(led_o), .atr_valid_o(atr_valid_o),
        .atr_data_o(atr_data_o), .atr_count_o(atr_count_o),
        .done_o(done_o), .no_card_o(no_card_o), .no_resp_o(no_resp_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle_dark();
        while (card_pwr_o) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int exp_cnt);
        rx_data_i  = b;
        rx_valid_i = 1'b1;
        @(negedge clk);
        rx_valid_i = 1'b0;
        chk("R6 capture strobe", int'(atr_valid_o), 1);
        chk("R6 capture data", int'(atr_data_o), int'(b));
        chk("R6 byte count", int'(atr_count_o), exp_cnt);
        @(negedge clk);
        chk("R6 single-cycle strobe", int'(atr_valid_o), 0);
    endtask

    initial begin
        int wd = 0;
        while (!finished && wd < WATCHDOG) begin
            @(posedge clk);
            wd++;
        end
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 power", int'(card_pwr_o), 0);
        chk("R1 reset out", int'(card_rst_n_o), 0);
        chk("R1 led", int'(led_o), 0);
        chk("R1 flags", int'({done_o, no_card_o, no_resp_o}), 0);
        chk("R1 count", int'(atr_count_o), 0);
        chk("R1 divider", int'(clk_div_sel_o), 0);
        chk("R1 supply class", int'(vcc_sel_o), 2);

        // Vector table of whole sessions
        for (int v = 0; v < NV; v++) begin
            card_present_i = VEC_PRES[v];
            pulse_start();
            if (VEC_PRES[v]) begin
                while (!card_rst_n_o) @(negedge clk);
                repeat (20) @(negedge clk);
                for (int b = 0; b < VEC_BYTES[v]; b++) begin
                    send_byte(8'h3B + 8'(b * 17), b + 1);
                    repeat (40) @(negedge clk);
                end
            end else begin
                repeat (4) @(negedge clk);
                chk("R2 power stays off", int'(card_pwr_o), 0);
                chk("R2 led stays off", int'(led_o), 0);
            end
            wait_idle_dark();
            chk("R2 no-card flag", int'(no_card_o), int'(VEC_NOCARD[v]));
            chk("R5 no-response flag", int'(no_resp_o), int'(VEC_NORESP[v]));
            chk("R7 done flag", int'(done_o), int'(VEC_DONE[v]));
            chk("R6 session byte count", int'(atr_count_o), VEC_BYTES[v]);
            chk("R9 power off at end", int'(card_pwr_o), 0);
            chk("R9 reset low at end", int'(card_rst_n_o), 0);
            chk("R9 led off at end", int'(led_o), 0);
        end

        // Directed: hold window, class before power, stray byte, no-response window
        card_present_i = 1'b1;
        pulse_start();
        chk("R10 flags cleared on start", int'({done_o, no_card_o, no_resp_o}), 0);
        chk("R10 count cleared on start", int'(atr_count_o), 0);
        chk("R3 led on", int'(led_o), 1);
        while (!card_pwr_o) @(negedge clk);
        chk("R3 divider before power", int'(clk_div_sel_o), 3);
        chk("R3 class before power", int'(vcc_sel_o), 1);
        cnt = 0;
        while (card_pwr_o && !card_rst_n_o) begin
            if (cnt == 5) rx_valid_i = 1'b1;
            if (cnt == 6) begin
                rx_valid_i = 1'b0;
                chk("R8 stray byte ignored strobe", int'(atr_valid_o), 0);
            end
            cnt++;
            @(negedge clk);
        end
        chk("R8 stray byte ignored count", int'(atr_count_o), 0);
        chk("R4 reset hold length", cnt, 8 * HOLD + 1);
        cnt = 0;
        while (card_rst_n_o) begin
            cnt++;
            @(negedge clk);
        end
        chk("R5 answer window length", cnt, 8 * (FIRST + GRACE * ETU) + 2);
        chk("R5 no-response raised", int'(no_resp_o), 1);
        chk("R9 power off after abort", int'(card_pwr_o), 0);
        wait_idle_dark();

        // Directed: silence timeout and start ignored while busy
        pulse_start();
        while (!card_rst_n_o) @(negedge clk);
        repeat (10) @(negedge clk);
        rx_data_i  = 8'hA5;
        rx_valid_i = 1'b1;
        @(negedge clk);
        rx_valid_i = 1'b0;
        chk("R6 directed byte", int'(atr_data_o), 8'hA5);
        cnt = 0;
        while (card_pwr_o) begin
            if (cnt == 50) start_i = 1'b1;
            if (cnt == 51) start_i = 1'b0;
            cnt++;
            @(negedge clk);
        end
        chk("R7 silence timeout length", cnt, WETU * (8 * ETU + 1) + 2);
        chk("R7 done raised", int'(done_o), 1);
        chk("R10 busy start kept count", int'(atr_count_o), 1);
        repeat (3) @(negedge clk);
        chk("R10 busy start no restart", int'(led_o), 0);

        // R10: next accepted start clears done
        pulse_start();
        chk("R10 done cleared", int'(done_o), 0);
        wait_idle_dark();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule